// File: doc/BRIEF.md
# Quarter-Rate Digital IF Upmixer

This block moves a complex baseband signal onto a real intermediate frequency that sits at exactly one quarter of the sample clock. It takes signed in-phase and quadrature words at the converter clock rate, marked by a valid strobe. It returns one signed real word, one bit wider than the inputs, for a single digital-to-analog path. Interpolation up to that rate happens upstream. Typical numbers are a 3.84 MHz chip rate multiplied by an integer factor such as 66, which gives a clock near 253 MHz.

The IF is pinned to a quarter of the clock, so each carrier only ever takes the values +1 and -1 at the sample instants. No oscillator table and no multiplier are needed. A two-bit phase count, which advances once per accepted sample, chooses which lanes to negate. The two lane results are then added in one registered adder. Negation saturates, so the most negative code becomes the most positive one and does not wrap.

Top module: `qrm_upmix_top`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` goes low and the carrier phase returns to 0, so the first accepted sample after reset uses phase 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and low after a cycle with `in_valid` low.
- R3: The carrier phase advances by one (modulo 4) only on cycles with `in_valid` high. Idle cycles leave it unchanged.
- R4: At phase 0 the result is `+I - Q`.
- R5: At phase 1 the result is `+I + Q`.
- R6: At phase 2 the result is `-I + Q`.
- R7: At phase 3 the result is `-I - Q`.
- R8: Negating the most negative input code (-2^(W-1)) gives 2^(W-1)-1.
- R9: The W+1-bit sum never wraps. With W=12 it reaches -4096 (phase 1, I=Q=-2048) and +4094 (phase 0, I=2047, Q=-2048).
- R10: `out_if` holds its value on cycles that follow a cycle with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a valid I/Q sample pair |
| in_i | input | DATA_W | Signed in-phase sample |
| in_q | input | DATA_W | Signed quadrature sample |
| out_valid | output | 1 | Output word is valid |
| out_if | output | DATA_W+1 | Signed real IF sample |

## Verification
A phase count that is out of step changes the sign pattern of the IF word. The first sample it affects comes out wrong one cycle later, and the error repeats with a period of four samples. A phase that moves on idle cycles looks the same, but it only appears on the first sample after a gap. A bad saturation path can be seen only when the extreme negative code meets a -1 carrier. For that reason the checks place that code at each phase where it gets negated, and on both sum extremes.

// File: rtl/qrm_pkg.sv
package qrm_pkg;
  localparam int PHASE_W = 2;
  typedef logic [PHASE_W-1:0] phase_t;

  // in-phase carrier: +1 +1 -1 -1 -> negate on phases 2,3
  function automatic logic neg_for_i(input phase_t ph);
    return ph[1];
  endfunction

  // quadrature carrier: -1 +1 +1 -1 -> negate on phases 0,3
  function automatic logic neg_for_q(input phase_t ph);
    return ~(ph[1] ^ ph[0]);
  endfunction
endpackage

// File: rtl/qrm_phase_gen.sv
module qrm_phase_gen
  import qrm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   adv,
  output phase_t phase
);
  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (adv) phase <= phase + 1'b1;
  end
endmodule

// File: rtl/qrm_sign_sel.sv
module qrm_sign_sel #(
  parameter int W = 12
) (
  input  logic [W-1:0] din,
  input  logic         neg,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  always_comb begin
    if (!neg)                dout = din;
    else if (din == MOST_NEG) dout = MOST_POS;
    else                     dout = (~din) + 1'b1;
  end
endmodule

// File: rtl/qrm_sum_reg.sv
module qrm_sum_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_in,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         vld_out,
  output logic [W:0]   sum
);
  logic [W:0] a_ext, b_ext;
  assign a_ext = {a[W-1], a};
  assign b_ext = {b[W-1], b};

  always_ff @(posedge clk) begin
    if (rst) vld_out <= 1'b0;
    else     vld_out <= vld_in;
  end

  always_ff @(posedge clk) begin
    if (rst)         sum <= '0;
    else if (vld_in) sum <= a_ext + b_ext;
  end
endmodule

// File: rtl/qrm_upmix_top.sv
module qrm_upmix_top
  import qrm_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  output logic              out_valid,
  output logic [DATA_W:0]   out_if
);
  localparam int LANES = 2;

  phase_t            phase;
  logic [DATA_W-1:0] lane_in  [LANES];
  logic [DATA_W-1:0] lane_out [LANES];
  logic              lane_neg [LANES];

  qrm_phase_gen u_phase (
    .clk  (clk),
    .rst  (rst),
    .adv  (in_valid),
    .phase(phase)
  );

  assign lane_in[0]  = in_i;
  assign lane_in[1]  = in_q;
  assign lane_neg[0] = neg_for_i(phase);
  assign lane_neg[1] = neg_for_q(phase);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    qrm_sign_sel #(.W(DATA_W)) u_sel (
      .din (lane_in[g]),
      .neg (lane_neg[g]),
      .dout(lane_out[g])
    );
  end

  qrm_sum_reg #(.W(DATA_W)) u_sum (
    .clk    (clk),
    .rst    (rst),
    .vld_in (in_valid),
    .a      (lane_out[0]),
    .b      (lane_out[1]),
    .vld_out(out_valid),
    .sum    (out_if)
  );
endmodule

// File: rtl/qrm_upmix_chk.sv
module qrm_upmix_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_i,
  input logic [DATA_W-1:0] in_q,
  input logic              out_valid,
  input logic [DATA_W:0]   out_if
);
  localparam logic signed [DATA_W:0] BIG = {2'b01, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W:0] LIM = {2'b00, {(DATA_W-1){1'b1}}};

  logic [1:0] mdl_ph;
  logic signed [DATA_W:0] wi, wq, pi, pq, mdl_sum;

  always_ff @(posedge clk) begin
    if (rst)           mdl_ph <= 2'd0;
    else if (in_valid) mdl_ph <= mdl_ph + 2'd1;
  end

  always_comb begin
    wi = $signed({in_i[DATA_W-1], in_i});
    wq = $signed({in_q[DATA_W-1], in_q});
    pi = (mdl_ph == 2'd0 || mdl_ph == 2'd1) ? wi : -wi;
    pq = (mdl_ph == 2'd1 || mdl_ph == 2'd2) ? wq : -wq;
    if (pi == BIG) pi = LIM;
    if (pq == BIG) pq = LIM;
    mdl_sum = pi + pq;
  end

  // R1
  reset_clears_valid_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_if));

  // R4 R5 R6 R7 R8 R9
  carrier_model_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_if == $past(mdl_sum)));
endmodule

bind qrm_upmix_top qrm_upmix_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_i     (in_i),
  .in_q     (in_q),
  .out_valid(out_valid),
  .out_if   (out_if)
);

// File: tb/qrm_upmix_top_tb.sv
`timescale 1ns/1ps
module qrm_upmix_top_tb;
  localparam int DATA_W = 12;
  localparam int NV = 16;
  localparam logic [DATA_W-1:0] VI [NV] = '{
    12'h001, 12'h010, 12'h100, 12'h7FF, 12'h800, 12'hFFF, 12'h123, 12'h800,
    12'h555, 12'hAAA, 12'h000, 12'h800, 12'h3E8, 12'hC18, 12'h7FF, 12'h800};
  localparam logic [DATA_W-1:0] VQ [NV] = '{
    12'h002, 12'h020, 12'h200, 12'h000, 12'h800, 12'h7FF, 12'h800, 12'h321,
    12'h0AA, 12'h800, 12'h800, 12'h800, 12'hFFF, 12'h001, 12'h7FF, 12'h001};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DATA_W-1:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic [DATA_W:0] out_if;

  int checks = 0, errors = 0, ph = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  qrm_upmix_top #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_if(out_if));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int apply(input logic [DATA_W-1:0] x, input bit neg);
    int v = $signed(x);
    if (!neg) return v;
    if (v == -(1 << (DATA_W-1))) return (1 << (DATA_W-1)) - 1;
    return -v;
  endfunction

  function automatic int expect_val(input logic [DATA_W-1:0] i, input logic [DATA_W-1:0] q, input int p);
    int ci = (p == 0 || p == 1) ? 1 : -1;
    int cq = (p == 1 || p == 2) ? 1 : -1;
    return apply(i, ci < 0) + apply(q, cq < 0);
  endfunction

  function automatic string ptag(input int p);
    case (p)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // called at a falling edge; returns at the next falling edge after checking
  task automatic send(input logic [DATA_W-1:0] i, input logic [DATA_W-1:0] q, input string tag);
    int e = expect_val(i, q, ph);
    in_valid = 1'b1; in_i = i; in_q = q;
    @(negedge clk);
    chk({"R2 ", tag}, int'(out_valid), 1);
    chk({ptag(ph), " ", tag}, $signed(out_if), e);
    ph = (ph + 1) % 4;
  endtask

  task automatic idle(input string tag);
    logic [DATA_W:0] held = out_if;
    in_valid = 1'b0; in_i = 12'h5A5; in_q = 12'hA5A;
    @(negedge clk);
    chk({"R2 ", tag}, int'(out_valid), 0);
    chk({"R10 ", tag}, int'(out_if), int'(held));
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) send(VI[k], VQ[k], "table");

    idle("gap a");
    idle("gap b");
    // R3: phase continues from 0 after idle cycles
    send(12'h040, 12'h004, "R3 after gap p0");
    idle("gap c");
    send(12'h040, 12'h004, "R3 after gap p1");
    // R8: most negative I negated at phase 2, Q=0
    send(12'h800, 12'h000, "R8 sat I");
    // R8: most negative Q negated at phase 3, I=0
    send(12'h000, 12'h800, "R8 sat Q");
    // R9: phase 0 positive extreme
    send(12'h7FF, 12'h800, "R9 max");
    // R9: phase 1 negative extreme
    send(12'h800, 12'h800, "R9 min");

    // R1: reset mid-stream
    send(12'h011, 12'h022, "pre reset");
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset valid", int'(out_valid), 0);
    rst = 1'b0; in_valid = 1'b0;
    ph = 0;
    @(negedge clk);
    send(12'h100, 12'h030, "R1 phase restart");
    send(12'h100, 12'h030, "R1 second after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule